// File: doc/BRIEF.md
# Timer Event Capture and Interrupt Unit

This unit gathers every event source of a precision time-protocol timer into a single sticky event register. A mask register with the same bit layout decides which pending events raise a level interrupt. Two asynchronous external trigger lines are brought into the clock domain, and on the selected edge of each one the unit stores the present 64-bit nanosecond time in that trigger's own capture register. Alarm-match pulses and periodic-pulse strobes from neighbouring timer blocks are recorded in the same register.

Software uses a 32-bit word-addressed register port. It enables sources in the mask register, picks the active trigger edges in the control register, reads the 64-bit captures as high and low words, and acknowledges events by writing ones to the event register. The running time counter is not part of the unit; it arrives on the `time_ns` input.

Register words, by `reg_addr`: 0 event, 1 mask, 2 control, 4 trigger-1 time high, 5 trigger-1 time low, 6 trigger-2 time high, 7 trigger-2 time low. Word 3 reads as zero.

Top module: `tmr_event_irq`

## Requirements
- R1: After reset the event, mask, control and both capture registers read zero and `irq` is low.
- R2: The event bits are: 25 for a trigger-2 capture, 24 for a trigger-1 capture, 17 for `alarm_hit[1]`, 16 for `alarm_hit[0]`, 7 for `pps_hit[0]`, 6 for `pps_hit[1]` and 5 for `pps_hit[2]`. A one-cycle pulse on an alarm or periodic-pulse input sets its bit, and the bit reads back set from the cycle after the pulse.
- R3: Writing the event word clears each bit written as 1 and leaves each bit written as 0 unchanged. A source that fires in the same cycle as a clear of its bit leaves the bit set.
- R4: `irq` is registered. It is high in the cycle after some event bit and the mask bit at the same position are both set, and low in the cycle after no such pair remains.
- R5: A trigger edge passes through a two-flop synchronizer and an edge detector. If the trigger input changes before clock edge k, then at edge k+2 the capture register takes the `time_ns` value present at that edge and the trigger's event bit sets. Neither is visible after edge k+1.
- R6: Control bit 8 selects the active edge for trigger 1 and control bit 9 for trigger 2: 0 means rising and 1 means falling. An edge of the opposite direction changes neither the capture register nor the event bit.
- R7: An active edge that arrives while the trigger's event bit is still set overwrites the capture register with the new time, and the event bit stays set.
- R8: The mask and event registers hold only bits 25, 24, 17, 16, 7, 6 and 5. The control register holds only bits 9 and 8. All other bits, and word 3, read as zero.
- R9: The two triggers are independent. An edge on one trigger changes neither the capture register nor the event bit of the other trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| time_ns | input | 64 | Current timer value in nanoseconds |
| trig_in | input | 2 | Asynchronous external triggers (bit 0 is trigger 1) |
| alarm_hit | input | 2 | One-cycle alarm-match pulses |
| pps_hit | input | 3 | One-cycle periodic-pulse strobes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check on every cycle that:
- an alarm pulse or a detected trigger edge sets its event bit in the next cycle,
- a capture register changes only after a detected edge, and then takes the time sampled at that edge,
- a pending bit survives any cycle without a clear aimed at it,
- `irq` stays low while the mask is empty.

Only the bench scenarios show the behaviours that depend on end-to-end timing or on a sequence of operations:
- the exact synchronizer latency,
- rejection of the opposite edge direction,
- overwrite of a capture while its event is pending,
- separation of the two triggers,
- read-back of reserved bits,
- priority of a set over a clear arriving in the same cycle, under random pulse and clear traffic.

// File: rtl/tmr_event_irq.sv
`timescale 1ns/1ps
module tmr_event_irq #(
  parameter int TIME_W = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_ns,
  input  logic [1:0]        trig_in,
  input  logic [1:0]        alarm_hit,
  input  logic [2:0]        pps_hit,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int HI_W = TIME_W - DATA_W;
  localparam logic [DATA_W-1:0] EV_VALID = DATA_W'(32'h0303_00E0);
  localparam logic [ADDR_W-1:0] A_EVENT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_T1HI  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_T1LO  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_T2HI  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_T2LO  = ADDR_W'(7);

  logic [DATA_W-1:0] ev_q, mask_q, ev_set, ev_clr, ctrl_word;
  logic [1:0] trig_pol, s1, s2, s3, trig_edge;
  logic [TIME_W-1:0] cap_q [2];

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_trig
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1[g] <= 1'b0;
          s2[g] <= 1'b0;
          s3[g] <= 1'b0;
        end else begin
          s1[g] <= trig_in[g];
          s2[g] <= s1[g];
          s3[g] <= s2[g];
        end
      end

      assign trig_edge[g] = trig_pol[g] ? (~s2[g] & s3[g]) : (s2[g] & ~s3[g]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cap_q[g] <= '0;
        else if (trig_edge[g]) cap_q[g] <= time_ns;
      end

      p_capture_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trig_edge[g] |=> (cap_q[g] == $past(time_ns)) && ev_q[24+g]);
      p_capture_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_edge[g] |=> $stable(cap_q[g]));
    end
  endgenerate

  always_comb begin
    ev_set     = '0;
    ev_set[24] = trig_edge[0];
    ev_set[25] = trig_edge[1];
    ev_set[16] = alarm_hit[0];
    ev_set[17] = alarm_hit[1];
    ev_set[7]  = pps_hit[0];
    ev_set[6]  = pps_hit[1];
    ev_set[5]  = pps_hit[2];
  end

  assign ev_clr = (reg_wr && reg_addr == A_EVENT) ? (reg_wdata & EV_VALID) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q     <= '0;
      mask_q   <= '0;
      trig_pol <= '0;
      irq      <= 1'b0;
    end else begin
      ev_q <= (ev_q & ~ev_clr) | ev_set;
      if (reg_wr && reg_addr == A_MASK) mask_q   <= reg_wdata & EV_VALID;
      if (reg_wr && reg_addr == A_CTRL) trig_pol <= reg_wdata[9:8];
      irq <= |(ev_q & mask_q);
    end
  end

  always_comb begin
    ctrl_word      = '0;
    ctrl_word[9:8] = trig_pol;
    case (reg_addr)
      A_EVENT: reg_rdata = ev_q;
      A_MASK:  reg_rdata = mask_q;
      A_CTRL:  reg_rdata = ctrl_word;
      A_T1HI:  reg_rdata = DATA_W'(cap_q[0][TIME_W-1 -: HI_W]);
      A_T1LO:  reg_rdata = cap_q[0][DATA_W-1:0];
      A_T2HI:  reg_rdata = DATA_W'(cap_q[1][TIME_W-1 -: HI_W]);
      A_T2LO:  reg_rdata = cap_q[1][DATA_W-1:0];
      default: reg_rdata = '0;
    endcase
  end

  p_alarm_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit[0] |=> ev_q[16]);
  p_pending_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q[24] && !(reg_wr && reg_addr == A_EVENT)) |=> ev_q[24]);
  p_quiet_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq);
endmodule

// File: tb/test_tmr_event_irq.sv
`timescale 1ns/1ps
module test_tmr_event_irq;
  logic        clk = 0, rst_n = 0;
  logic [63:0] time_ns = '0;
  logic [1:0]  trig_in = '0, alarm_hit = '0;
  logic [2:0]  pps_hit = '0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq;
  int checks = 0, failures = 0;
  localparam logic [31:0] VALID = 32'h0303_00E0;

  tmr_event_irq i_tmr_event_irq (.clk, .rst_n, .time_ns, .trig_in, .alarm_hit,
    .pps_hit, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .irq);

  always #2.5 clk = ~clk;

  function automatic logic [31:0] src_bits(logic [1:0] a, logic [2:0] p);
    logic [31:0] v = '0;
    v[16] = a[0]; v[17] = a[1];
    v[7] = p[0]; v[6] = p[1]; v[5] = p[2];
    return v;
  endfunction
  function automatic logic [31:0] next_ev(logic [31:0] ev, logic [31:0] clr, logic [31:0] set);
    return (ev & ~(clr & VALID)) | set;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask
  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask
  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask
  task automatic rd64(logic [2:0] hi, output logic [63:0] v);
    logic [31:0] h, l;
    rd(hi, h); rd(hi + 3'd1, l); v = {h, l};
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d, ev_m, mask_m, old, setv, clrv;
    logic [63:0] v, t1, t2;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      if (a == 3) continue;
      rd(a[2:0], d); chk("R1 reset reg", d, 0);
    end
    chk("R1 reset irq", irq, 0);

    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, d); chk("R8 mask reserved", d, VALID);
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, d); chk("R8 ctrl reserved", d, 32'h300);
    rd(3'd3, d); chk("R8 word3", d, 0);
    wr(3'd2, 0);

    // trigger 1 rising; mask only bit 24
    wr(3'd1, 32'h0100_0000);
    t1 = {$urandom, $urandom};
    @(negedge clk); time_ns = t1; trig_in[0] = 1;
    cyc(2);
    rd(3'd0, d); chk("R5 not yet after k+1", d[24], 0);
    cyc(1);
    rd(3'd0, d); chk("R5 event bit", d[24], 1);
    rd64(3'd4, v); chk("R5 capture value", v, t1);
    chk("R4 irq still low", irq, 0);
    rd64(3'd6, v); chk("R9 trig2 capture untouched", v, 0);
    chk("R9 trig2 bit clear", d[25], 0);
    time_ns = t1 + 64'd999;
    cyc(1); chk("R4 irq high", irq, 1);

    // falling edge with rising polarity: no effect
    trig_in[0] = 0; cyc(5);
    rd64(3'd4, v); chk("R6 opposite edge ignored", v, t1);
    // overwrite while pending
    t2 = {$urandom, $urandom}; time_ns = t2; trig_in[0] = 1; cyc(3);
    rd64(3'd4, v); chk("R7 overwrite", v, t2);
    rd(3'd0, d); chk("R7 bit stays", d[24], 1);

    wr(3'd0, 32'h0100_0000);
    rd(3'd0, d); chk("R3 cleared", d[24], 0);
    chk("R4 irq lags clear", irq, 1);
    cyc(1); chk("R4 irq low", irq, 0);

    // trigger 1 falling polarity
    wr(3'd2, 32'h100);
    trig_in[0] = 0; t1 = {$urandom, $urandom}; time_ns = t1; cyc(3);
    rd64(3'd4, v); chk("R6 falling capture", v, t1);
    rd(3'd0, d); chk("R6 falling bit", d[24], 1);
    wr(3'd0, 32'h0100_0000);
    trig_in[0] = 1; time_ns = 64'h5; cyc(5);
    rd(3'd0, d); chk("R6 rising ignored bit", d[24], 0);
    rd64(3'd4, v); chk("R6 rising ignored cap", v, t1);

    // trigger 2 falling (bit 9), trigger 1 unaffected
    wr(3'd2, 32'h200);
    trig_in[1] = 1; cyc(5);
    rd(3'd0, d); chk("R6 trig2 rising ignored", d[25], 0);
    t2 = {$urandom, $urandom}; time_ns = t2; trig_in[1] = 0; cyc(3);
    rd64(3'd6, v); chk("R5 trig2 capture", v, t2);
    rd(3'd0, d); chk("R2 trig2 bit25", d[25], 1);
    chk("R9 trig1 bit clear", d[24], 0);
    rd64(3'd4, v); chk("R9 trig1 cap kept", v, t1);
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd2, 0);

    // set wins over clear in same cycle
    @(negedge clk); alarm_hit = 2'b01; reg_wr = 1; reg_addr = 0; reg_wdata = 32'h0001_0000;
    @(negedge clk); alarm_hit = 0; reg_wr = 0;
    rd(3'd0, d); chk("R3 set beats clear", d[16], 1);
    wr(3'd0, 32'hFFFF_FFFF);

    // random pulse / clear traffic
    mask_m = $urandom & VALID; mask_m[24] = 0; mask_m[25] = 0;
    wr(3'd1, mask_m);
    ev_m = 0; reg_addr = 0;
    cyc(1);
    for (int i = 0; i < 400; i++) begin
      alarm_hit = ($urandom % 4 == 0) ? 2'($urandom) : 2'b0;
      pps_hit   = ($urandom % 4 == 0) ? 3'($urandom) : 3'b0;
      reg_wr    = ($urandom % 3 == 0);
      reg_wdata = $urandom;
      setv = src_bits(alarm_hit, pps_hit);
      clrv = reg_wr ? reg_wdata : 32'h0;
      @(negedge clk);
      old = ev_m;
      ev_m = next_ev(ev_m, clrv, setv);
      #0.5;
      chk("R2 R3 event reg", reg_rdata, ev_m);
      chk("R4 irq", irq, |(old & mask_m));
      alarm_hit = 0; pps_hit = 0; reg_wr = 0;
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule